// File: doc/BRIEF.md
# Two-Step Timestamp Queue

This block buffers hardware timestamps for two-step precision time transmission until host software collects them. Whenever the egress datapath sends an event frame that needs a follow-up message, it hands the block one event carrying the departure time and the egress port. The block stores that event as two consecutive entries. The first entry holds the time and port and is flagged as a transmit stamp. The second entry holds a frame identifier, which the block numbers itself, packed into the nanosecond and sub-nanosecond fields. Other timestamps that are not transmit stamps can be pushed as single entries with the transmit flag clear.

The host sees the head entry through a small status group: valid, a sticky overflow flag, the transmit flag and the port. Two data outputs carry the head nanosecond and sub-nanosecond values. A one-cycle pop strobe retires the head entry. A one-cycle clear strobe resets the overflow flag. A transmit event is always stored or dropped as a whole, so the host never sees a time entry without its identifier entry.

Top module: `ts_pair_fifo`

## Requirements
- R1: After reset the queue is empty. `st_valid`, `st_ovfl`, `st_tx`, `st_port`, `hd_ns` and `hd_sub` are all zero.
- R2: An accepted transmit event writes two adjacent entries.
  - The first has `st_tx`=1, the event port, and the event nanosecond and sub-nanosecond values.
  - The second has `st_tx`=0 and port 0, and carries the frame identifier.
- R3: The identifier entry has `hd_ns` = identifier >> 8 and `hd_sub` = identifier[7:0].
  - The identifier is 0 for the first accepted event after reset.
  - It rises by one for each accepted event and wraps from 511 to 0.
- R4: An accepted single-entry push writes one entry with `st_tx`=0, port 0, and the given nanosecond and sub-nanosecond values.
- R5: A pop strobe while `st_valid`=1 retires the head entry, and the next entry, if any, is shown in the following cycle. A pop strobe while the queue is empty has no effect.
- R6: A transmit event that finds fewer than two free slots is dropped whole and sets `st_ovfl`. A dropped event does not consume an identifier.
- R7: A single-entry push that finds the queue full is dropped and sets `st_ovfl`.
- R8: `st_ovfl` stays set until `ovf_clr` is pulsed. If a drop happens in the same cycle as the clear, the flag stays set.
- R9: When a transmit event and a single-entry push arrive in the same cycle, the pair is queued first. The single entry is accepted only if a slot remains after the pair.
- R10: Without a pop, the head entry's outputs stay unchanged while `st_valid`=1.
- R11: Free space is judged on the occupancy before any same-cycle pop. On a full queue, a transmit event that arrives together with a pop is dropped.

Entries leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Transmit event strobe (pushes a pair) |
| ev_port | input | PORT_W | Egress port of the event |
| ev_ns | input | NS_W | Departure time, nanoseconds |
| ev_sub | input | SUB_W | Departure time, sub-nanoseconds |
| ing_valid | input | 1 | Single-entry push strobe (transmit flag clear) |
| ing_ns | input | NS_W | Single entry nanoseconds |
| ing_sub | input | SUB_W | Single entry sub-nanoseconds |
| pop | input | 1 | Retire the head entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| st_valid | output | 1 | Head entry present |
| st_ovfl | output | 1 | Sticky overflow flag |
| st_tx | output | 1 | Head entry is a transmit stamp |
| st_port | output | PORT_W | Head entry port |
| hd_ns | output | NS_W | Head entry nanoseconds |
| hd_sub | output | SUB_W | Head entry sub-nanoseconds |

## Verification
Faults in the read pointer, write pointer or occupancy counter show up as a head entry that does not match the write order. Such an error appears at the first pop after the fault, or within one cycle as a lost or phantom `st_valid`. An error in the identifier counter or the pair packing shows as a wrong `hd_ns`/`hd_sub` on the second entry of the next pair. Wrong free-space arithmetic shows only at the full boundary, as a missing or spurious `st_ovfl` in the cycle after the push. For that reason the queue is driven to exactly full and to one slot free. The identifier is also run through its wrap.

// File: rtl/ts_pair_fifo.sv
module ts_pair_fifo #(
  parameter int DEPTH  = 32,
  parameter int NS_W   = 30,
  parameter int SUB_W  = 8,
  parameter int PORT_W = 7,
  parameter int ID_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [NS_W-1:0]   ev_ns,
  input  logic [SUB_W-1:0]  ev_sub,
  input  logic              ing_valid,
  input  logic [NS_W-1:0]   ing_ns,
  input  logic [SUB_W-1:0]  ing_sub,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic              st_valid,
  output logic              st_ovfl,
  output logic              st_tx,
  output logic [PORT_W-1:0] st_port,
  output logic [NS_W-1:0]   hd_ns,
  output logic [SUB_W-1:0]  hd_sub
);
  // DEPTH must be a power of two (pointers wrap naturally)
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 1 + PORT_W + SUB_W + NS_W;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [ID_W-1:0] id_ctr;
  logic ovfl;

  logic [CW-1:0] free, ing_room;
  logic pair_ok, ing_ok, pop_ok, drop;
  logic [AW-1:0] wp1, wp2, ing_wp;
  logic [EW-1:0] e_first, e_second, e_single, head;
  logic [NS_W-1:0] id_ns;

  assign free     = CW'(DEPTH) - count;
  assign pair_ok  = ev_valid && (free >= CW'(2));
  assign ing_room = pair_ok ? free - CW'(2) : free;
  assign ing_ok   = ing_valid && (ing_room != '0);
  assign pop_ok   = pop && (count != '0);
  assign drop     = (ev_valid && !pair_ok) || (ing_valid && !ing_ok);

  assign wp1    = wr_ptr + AW'(1);
  assign wp2    = wr_ptr + AW'(2);
  assign ing_wp = pair_ok ? wp2 : wr_ptr;

  assign id_ns    = NS_W'(id_ctr >> SUB_W);
  assign e_first  = {1'b1, ev_port, ev_sub, ev_ns};
  assign e_second = {1'b0, {PORT_W{1'b0}}, id_ctr[SUB_W-1:0], id_ns};
  assign e_single = {1'b0, {PORT_W{1'b0}}, ing_sub, ing_ns};

  always_ff @(posedge clk) begin
    if (pair_ok) begin
      mem[wr_ptr] <= e_first;
      mem[wp1]    <= e_second;
    end
    if (ing_ok) mem[ing_wp] <= e_single;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      id_ctr <= '0;
      ovfl   <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + AW'(pair_ok ? 2 : 0) + AW'(ing_ok);
      rd_ptr <= rd_ptr + AW'(pop_ok);
      count  <= count + CW'(pair_ok ? 2 : 0) + CW'(ing_ok) - CW'(pop_ok);
      if (pair_ok) id_ctr <= id_ctr + ID_W'(1);
      ovfl   <= (ovfl && !ovf_clr) || drop;
    end
  end

  assign head     = mem[rd_ptr];
  assign st_valid = (count != '0);
  assign st_ovfl  = ovfl;
  assign st_tx    = st_valid && head[EW-1];
  assign st_port  = st_valid ? head[EW-2 -: PORT_W] : '0;
  assign hd_sub   = st_valid ? head[NS_W +: SUB_W] : '0;
  assign hd_ns    = st_valid ? head[NS_W-1:0] : '0;
endmodule

// File: rtl/ts_pair_fifo_chk.sv
module ts_pair_fifo_chk #(
  parameter int DEPTH  = 32,
  parameter int NS_W   = 30,
  parameter int SUB_W  = 8,
  parameter int PORT_W = 7,
  parameter int CW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ing_valid,
  input logic              pop,
  input logic              ovf_clr,
  input logic              st_valid,
  input logic              st_ovfl,
  input logic              st_tx,
  input logic [PORT_W-1:0] st_port,
  input logic [NS_W-1:0]   hd_ns,
  input logic [SUB_W-1:0]  hd_sub,
  input logic [CW-1:0]     count
);
  assert_sticky_ovfl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovfl && !ovf_clr |=> st_ovfl);

  assert_clear_ovfl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !ev_valid && !ing_valid |=> !st_ovfl);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid && !ev_valid && !ing_valid |=> !st_valid);

  assert_pair_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_tx && pop |=> st_valid && !st_tx);

  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !pop |=> st_valid && $stable(hd_ns) && $stable(hd_sub)
                         && $stable(st_tx) && $stable(st_port));

  assert_full_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) && ing_valid |=> st_ovfl);

  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind ts_pair_fifo ts_pair_fifo_chk #(
  .DEPTH(DEPTH), .NS_W(NS_W), .SUB_W(SUB_W), .PORT_W(PORT_W), .CW(CW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ing_valid(ing_valid),
  .pop(pop), .ovf_clr(ovf_clr), .st_valid(st_valid), .st_ovfl(st_ovfl),
  .st_tx(st_tx), .st_port(st_port), .hd_ns(hd_ns), .hd_sub(hd_sub),
  .count(count)
);

// File: tb/test_ts_pair_fifo.sv
module test_ts_pair_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32, NS_W = 30, SUB_W = 8, PORT_W = 7;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ing_valid = 0, pop = 0, ovf_clr = 0;
  logic [PORT_W-1:0] ev_port = 0;
  logic [NS_W-1:0] ev_ns = 0, ing_ns = 0;
  logic [SUB_W-1:0] ev_sub = 0, ing_sub = 0;
  logic st_valid, st_ovfl, st_tx;
  logic [PORT_W-1:0] st_port;
  logic [NS_W-1:0] hd_ns;
  logic [SUB_W-1:0] hd_sub;

  ts_pair_fifo i_ts_pair_fifo (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  // model entry: {tx, port, sub, ns}
  logic [1+PORT_W+SUB_W+NS_W-1:0] q[$];
  logic m_ovf = 0;
  int m_id = 0;

  // one cycle of stimulus, with model prediction from the requirements
  task automatic cyc(input bit ev, input int port, input int ns, input int sub,
                     input bit ing, input int ins, input int isub,
                     input bit p, input bit clr);
    int free;
    bit had;
    had = q.size() > 0;
    free = DEPTH - q.size();
    ev_valid = ev; ev_port = PORT_W'(port); ev_ns = NS_W'(ns); ev_sub = SUB_W'(sub);
    ing_valid = ing; ing_ns = NS_W'(ins); ing_sub = SUB_W'(isub);
    pop = p; ovf_clr = clr;
    if (p && had) void'(q.pop_front());
    if (clr) m_ovf = 0;
    if (ev) begin
      if (free >= 2) begin
        q.push_back({1'b1, PORT_W'(port), SUB_W'(sub), NS_W'(ns)});
        q.push_back({1'b0, PORT_W'(0), SUB_W'(m_id & 255), NS_W'(m_id >> 8)});
        m_id = (m_id + 1) % 512;
        free -= 2;
      end else m_ovf = 1;
    end
    if (ing) begin
      if (free >= 1) q.push_back({1'b0, PORT_W'(0), SUB_W'(isub), NS_W'(ins)});
      else m_ovf = 1;
    end
    @(negedge clk);
    ev_valid = 0; ing_valid = 0; pop = 0; ovf_clr = 0;
  endtask

  task automatic chk_head(input string tag);
    logic [1+PORT_W+SUB_W+NS_W-1:0] e;
    bit ev; bit et; int ep, es, en;
    ev = q.size() > 0;
    e = ev ? q[0] : '0;
    {et, ep, es, en} = {e[PORT_W+SUB_W+NS_W], 32'(e[NS_W+SUB_W +: PORT_W]),
                        32'(e[NS_W +: SUB_W]), 32'(e[NS_W-1:0])};
    total++;
    if (st_valid !== ev || st_tx !== et || st_port !== PORT_W'(ep) ||
        hd_sub !== SUB_W'(es) || hd_ns !== NS_W'(en) || st_ovfl !== m_ovf) begin
      bad++;
      $display("FAIL %s: got v=%0d o=%0d t=%0d p=%0d sub=%0d ns=%0d exp v=%0d o=%0d t=%0d p=%0d sub=%0d ns=%0d",
               tag, st_valid, st_ovfl, st_tx, st_port, hd_sub, hd_ns,
               ev, m_ovf, et, ep, es, en);
    end
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,0); endtask
  task automatic push_pair(input int port, input int ns, input int sub); cyc(1,port,ns,sub,0,0,0,0,0); endtask
  task automatic push_one(input int ns, input int sub); cyc(0,0,0,0,1,ns,sub,0,0); endtask
  task automatic do_pop(); cyc(0,0,0,0,0,0,0,1,0); endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin chk_head(tag); do_pop(); end
    chk_head(tag);
  endtask

  task automatic t_reset();
    chk_head("R1 reset");
  endtask

  task automatic t_basic();
    push_pair(5, 123456789, 77);
    push_pair(127, 999999999, 255);
    drain("R2 R3 pair content");
  endtask

  task automatic t_ingress();
    push_one(42, 9);
    push_pair(3, 1000, 1);
    push_one(7, 200);
    drain("R4 single entry");
  endtask

  task automatic t_empty_pop();
    do_pop(); do_pop();
    chk_head("R5 pop on empty");
    push_pair(11, 55, 66);
    chk_head("R5 head after empty pop");
    drain("R5 order");
  endtask

  task automatic t_hold();
    push_pair(9, 314, 15);
    for (int i = 0; i < 4; i++) begin idle(); chk_head("R10 hold"); end
    drain("R10 drain");
  endtask

  task automatic t_fill_drop();
    for (int i = 0; i < DEPTH/2; i++) push_pair(i, 100 + i, i);
    chk_head("R6 full");
    push_pair(1, 2, 3);
    chk_head("R6 pair dropped full");
    push_one(5, 5);
    chk_head("R7 single dropped full");
    drain("R6 drain after drop");
    cyc(0,0,0,0,0,0,0,0,1);
    for (int i = 0; i < DEPTH-1; i++) push_one(i, i);
    push_pair(2, 20, 2);
    chk_head("R6 one slot free pair dropped");
    push_one(777, 7);
    chk_head("R7 last slot taken");
    push_pair(4, 40, 4);
    drain("R6 id not consumed");
  endtask

  task automatic t_ovf_clear();
    cyc(0,0,0,0,0,0,0,0,1);
    chk_head("R8 cleared");
    for (int i = 0; i < DEPTH; i++) push_one(i, 1);
    push_one(1, 1);
    idle(); idle();
    chk_head("R8 sticky");
    cyc(0,0,0,0,1,3,3,0,1);
    chk_head("R8 set wins over clear");
    cyc(0,0,0,0,0,0,0,0,1);
    chk_head("R8 clear");
    drain("R8 drain");
  endtask

  task automatic t_same_cycle();
    cyc(1, 6, 600, 6, 1, 700, 7, 0, 0);
    chk_head("R9 both accepted");
    for (int i = 0; i < DEPTH-6; i++) push_one(i, 0);
    cyc(1, 8, 800, 8, 1, 900, 9, 0, 0);
    chk_head("R9 pair wins last slots");
    drain("R9 order");
    cyc(0,0,0,0,0,0,0,0,1);
  endtask

  task automatic t_pop_full();
    for (int i = 0; i < DEPTH/2; i++) push_pair(i, i, i);
    cyc(1, 1, 1, 1, 0, 0, 0, 1, 0);
    chk_head("R11 pair dropped despite pop");
    drain("R11 drain");
    cyc(0,0,0,0,0,0,0,0,1);
  endtask

  task automatic t_id_wrap();
    for (int i = 0; i < 520; i++) begin
      push_pair(i % 128, i, i);
      chk_head("R3 wrap tx");
      do_pop();
      chk_head("R3 wrap id");
      do_pop();
    end
    chk_head("R3 wrap end");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL all: watchdog expired got running exp finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ingress();
    t_empty_pop();
    t_hold();
    t_fill_drop();
    t_ovf_clear();
    t_same_cycle();
    t_pop_full();
    t_id_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule